// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block turns eight asynchronous external pins into clean interrupt requests. Each channel picks one pin out of a shared group of candidate pins. The picked pin is brought into the system clock domain, then optionally cleaned by a short majority-free agreement filter, and then optionally slowed down by a low-rate sampler. A configurable edge detector finally produces one-cycle request pulses for the interrupt controller.

Every channel also drives a timer-trigger level. That level always passes through the agreement filter and never through the low-rate sampler, whatever the channel's own filter and sampling settings are.

Configuration is taken from static register-style inputs: pin select, edge mode, filter enable and sampling enable. Any change of these inputs opens a short quiet window. During that window the downstream stages follow their inputs without raising requests, so reconfiguring a channel never produces a false interrupt.

Top module: `extirq_cond`

## Requirements
- R1: With filter and sampler bypassed, a pin change driven between clock edges shows as a request pulse during the third cycle after the drive. Two synchronizer flops and the request register make up that delay.
- R2: Edge mode 2'b01 (rising) raises a request only on a low-to-high change of the conditioned input.
- R3: Edge mode 2'b10 (falling) raises a request only on a high-to-low change of the conditioned input.
- R4: Edge mode 2'b11 (both) raises a separate request for every change of the conditioned input.
- R5: Edge mode 2'b00 disables the channel, so no requests are raised.
- R6: A pin change that is held steady yields exactly one request pulse of one cycle.
- R7: When the filter is enabled, a new level passes only after three consecutive clock samples agree. A 2-cycle pulse is rejected, and a held change shows as a request in the sixth cycle after the drive.
- R8: When sampling is enabled, a new level passes only when two consecutive low-rate ticks (`lsc_tick`, a one-cycle enable) see it. A pulse that lies wholly between two ticks is ignored.
- R9: `trig[n]` is the filtered level of channel n's selected pin, whatever `cfg_filt` and `cfg_samp` say. It rises in the fifth cycle after the pin rises, and it stays low for a 2-cycle pulse.
- R10: Channel n follows `pins[cfg_sel[n*SELW +: SELW]]`, and pins that are not selected have no effect on it.
- R11: A change of any of a channel's configuration inputs raises no request, even when a real pin change arrives in the same cycle. The edge reference is reloaded for FILT_LEN+3 cycles.
- R12: While reset is held and right after it is released, `irq` and `trig` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lsc_tick | input | 1 | One-cycle enable at half the low-speed clock rate |
| pins | input | NPIN | Candidate external pins (asynchronous) |
| cfg_sel | input | NCH*SELW | Per-channel pin index |
| cfg_mode | input | NCH*2 | Per-channel edge mode (00 off, 01 rise, 10 fall, 11 both) |
| cfg_filt | input | NCH | Per-channel filter enable for the request path |
| cfg_samp | input | NCH | Per-channel low-rate sampling enable for the request path |
| irq | output | NCH | One-cycle interrupt request pulses |
| trig | output | NCH | Filtered, unsampled level for a timer trigger |

## Verification
A configuration write and a real pin edge can land on the same clock edge. In that case the quiet-window reload and the edge detector compete for the same reference register. The bench changes a channel's edge mode and its pin level at the same instant and expects no pulse. It then drops the pin and expects exactly one pulse at the unfiltered latency, which shows that the reference took the new level and not the old one. The other coincidence is a pin-select switch onto a pin at a different level, which must also stay silent.

// File: rtl/extirq_pkg.sv
// Package: shared types for the external interrupt conditioner.
// Assumes: edge mode bit 0 enables rising detection, bit 1 enables falling.
package extirq_pkg;
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;
endpackage

// File: rtl/extirq_filt.sv
// Module: agreement filter. The output takes a new level only after
// FILT_LEN consecutive clock samples of the input agree on it.
// Assumes: input is already synchronous to clk; FILT_LEN >= 2.
module extirq_filt #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int HW = FILT_LEN - 1;

    logic [HW-1:0] hist;
    logic          all_hi;
    logic          all_lo;

    // Detect unanimous windows of the current input plus history.
    always_comb begin
        all_hi = &{hist, d};
        all_lo = ~|{hist, d};
    end

    // Shift the history and update the output on agreement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
            q    <= 1'b0;
        end else begin
            hist <= (hist << 1) | HW'(d);
            if (all_hi)      q <= 1'b1;
            else if (all_lo) q <= 1'b0;
        end
    end

    // The output may only move to the level the input held beforehand.
    p_filt_agree_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q) |-> ($past(d) == q));
endmodule

// File: rtl/extirq_samp.sv
// Module: low-rate two-phase sampler. On each tick the input is sampled;
// the output changes only when two consecutive tick samples agree.
// Assumes: tick is a one-cycle enable; ld forces the output to follow d.
module extirq_samp (
    input  logic clk,
    input  logic rst_n,
    input  logic ld,
    input  logic tick,
    input  logic d,
    output logic q
);
    logic last;

    // Sample on ticks, accept on two-phase agreement, track during load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last <= 1'b0;
            q    <= 1'b0;
        end else if (ld) begin
            last <= d;
            q    <= d;
        end else if (tick) begin
            last <= d;
            if (d == last) q <= d;
        end
    end

    // Outside a load, the output moves only on a tick.
    p_samp_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(q) && !$past(ld)) |-> $past(tick));
endmodule

// File: rtl/extirq_edge.sv
// Module: edge detector producing one-cycle request pulses.
// Assumes: cond is synchronous; ld reloads the reference and blocks requests.
module extirq_edge
    import extirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld,
    input  edge_mode_e mode,
    input  logic       cond,
    output logic       irq
);
    logic prev;
    logic rise_en;
    logic fall_en;

    // Decode which transitions the current mode qualifies.
    always_comb begin
        rise_en = (mode == EDGE_RISE) || (mode == EDGE_BOTH);
        fall_en = (mode == EDGE_FALL) || (mode == EDGE_BOTH);
    end

    // Track the previous level and register the request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= 1'b0;
            irq  <= 1'b0;
        end else begin
            prev <= cond;
            if (ld) irq <= 1'b0;
            else    irq <= (cond & ~prev & rise_en) | (~cond & prev & fall_en);
        end
    end

    p_rise_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(mode) == EDGE_RISE) |-> prev);
    p_fall_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(mode) == EDGE_FALL) |-> !prev);
    p_req_on_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (prev != $past(prev)));
    p_off_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == EDGE_OFF) |=> !irq);
    p_quiet_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> !irq);
endmodule

// File: rtl/extirq_chan.sv
// Module: one conditioning channel: pin select, synchronizer, filter,
// sampler, edge detector and configuration-change quiet window.
// Assumes: configuration inputs are synchronous to clk.
module extirq_chan
    import extirq_pkg::*;
#(
    parameter int NPIN     = 16,
    parameter int FILT_LEN = 3,
    parameter int SELW     = (NPIN > 1) ? $clog2(NPIN) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [NPIN-1:0] pins,
    input  logic [SELW-1:0] sel,
    input  edge_mode_e      mode,
    input  logic            filt_en,
    input  logic            samp_en,
    output logic            irq,
    output logic            trig
);
    localparam int CFGW      = SELW + 4;
    localparam int QUIET_CYC = FILT_LEN + 3;
    localparam int QW        = $clog2(QUIET_CYC + 1);

    logic [CFGW-1:0] cfg_w;
    logic [CFGW-1:0] cfg_q;
    logic            chg;
    logic [QW-1:0]   quiet_cnt;
    logic            ld;
    logic            pin_raw;
    logic [1:0]      sync_r;
    logic            filt_q;
    logic            pre_samp;
    logic            samp_q;
    logic            cond;

    // Gather the configuration and select the source pin.
    always_comb begin
        cfg_w   = {sel, mode, filt_en, samp_en};
        chg     = (cfg_w != cfg_q);
        ld      = chg || (quiet_cnt != '0);
        pin_raw = pins[sel];
    end

    // Two-flop synchronizer into the system clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_r <= 2'b00;
        else        sync_r <= {sync_r[0], pin_raw};
    end

    // Remember the configuration and run the quiet window after changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            quiet_cnt <= '0;
        end else begin
            cfg_q <= cfg_w;
            if (chg)                  quiet_cnt <= QW'(QUIET_CYC);
            else if (quiet_cnt != '0) quiet_cnt <= quiet_cnt - 1'b1;
        end
    end

    extirq_filt #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sync_r[1]),
        .q     (filt_q)
    );

    // Choose the request-path source ahead of the sampler.
    always_comb pre_samp = filt_en ? filt_q : sync_r[1];

    extirq_samp u_samp (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (ld),
        .tick  (tick),
        .d     (pre_samp),
        .q     (samp_q)
    );

    // Choose the conditioned value and the always-filtered trigger.
    always_comb begin
        cond = samp_en ? samp_q : pre_samp;
        trig = filt_q;
    end

    extirq_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (ld),
        .mode  (mode),
        .cond  (cond),
        .irq   (irq)
    );

    p_cfg_opens_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> (quiet_cnt != '0));
endmodule

// File: rtl/extirq_cond.sv
// Module: top of the external interrupt conditioner; one channel per
// generate iteration, configuration sliced from flat vectors.
// Assumes: lsc_tick is a one-cycle enable synchronous to clk.
module extirq_cond
    import extirq_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int NPIN     = 16,
    parameter int FILT_LEN = 3,
    parameter int SELW     = (NPIN > 1) ? $clog2(NPIN) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lsc_tick,
    input  logic [NPIN-1:0]     pins,
    input  logic [NCH*SELW-1:0] cfg_sel,
    input  logic [NCH*2-1:0]    cfg_mode,
    input  logic [NCH-1:0]      cfg_filt,
    input  logic [NCH-1:0]      cfg_samp,
    output logic [NCH-1:0]      irq,
    output logic [NCH-1:0]      trig
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        extirq_chan #(
            .NPIN     (NPIN),
            .FILT_LEN (FILT_LEN),
            .SELW     (SELW)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (lsc_tick),
            .pins    (pins),
            .sel     (cfg_sel[c*SELW +: SELW]),
            .mode    (edge_mode_e'(cfg_mode[c*2 +: 2])),
            .filt_en (cfg_filt[c]),
            .samp_en (cfg_samp[c]),
            .irq     (irq[c]),
            .trig    (trig[c])
        );
    end
endmodule

// File: tb/extirq_cond_tb.sv
module extirq_cond_tb;
    localparam int NCH      = 8;
    localparam int NPIN     = 16;
    localparam int SELW     = 4;
    localparam int TICK_DIV = 8;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                lsc_tick;
    logic [NPIN-1:0]     pins;
    logic [NCH*SELW-1:0] cfg_sel;
    logic [NCH*2-1:0]    cfg_mode;
    logic [NCH-1:0]      cfg_filt;
    logic [NCH-1:0]      cfg_samp;
    logic [NCH-1:0]      irq;
    logic [NCH-1:0]      trig;

    int n_chk = 0;
    int n_err = 0;
    int tcnt  = 0;
    int cnt, first;
    logic thi;

    always #2 clk = ~clk;

    extirq_cond #(.NCH(NCH), .NPIN(NPIN)) u_dut (
        .clk(clk), .rst_n(rst_n), .lsc_tick(lsc_tick), .pins(pins),
        .cfg_sel(cfg_sel), .cfg_mode(cfg_mode), .cfg_filt(cfg_filt),
        .cfg_samp(cfg_samp), .irq(irq), .trig(trig)
    );

    // Vector: [19:16] req, [15:12] sel, [11:10] mode, [9] filt, [8] samp,
    // [7] start level, [6] new level, [5:4] pulses, [3:0] latency (0 = skip)
    localparam logic [19:0] VEC [12] = '{
        {4'd2, 4'd0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 4'd3}, // R2 rise
        {4'd2, 4'd0, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 4'd0}, // R2 no fall
        {4'd3, 4'd2, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 4'd3}, // R3 fall
        {4'd3, 4'd2, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 4'd0}, // R3 no rise
        {4'd4, 4'd5, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 4'd3}, // R4 up
        {4'd4, 4'd5, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 4'd3}, // R4 down
        {4'd5, 4'd5, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 4'd0}, // R5 off
        {4'd7, 4'd0, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 4'd6}, // R7 rise
        {4'd7, 4'd0, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 4'd6}, // R7 fall
        {4'd8, 4'd9, 2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 4'd0}, // R8 rise
        {4'd8, 4'd9, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 4'd0}, // R8 fall
        {4'd8, 4'd9, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 4'd0}  // R8 both
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_ch(input int ch, input int sel, input logic [1:0] mode,
                          input logic f, input logic s);
        cfg_sel[ch*SELW +: SELW] = SELW'(sel);
        cfg_mode[ch*2 +: 2]      = mode;
        cfg_filt[ch]             = f;
        cfg_samp[ch]             = s;
    endtask

    task automatic watch(input int ch, input int n, output int c, output int f,
                         output logic t);
        c = 0; f = 0; t = 1'b0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (irq[ch]) begin
                c++;
                if (f == 0) f = i;
            end
            if (trig[ch]) t = 1'b1;
        end
    endtask

    // Low-rate tick: one cycle high every TICK_DIV cycles.
    initial begin
        lsc_tick = 1'b0;
        forever begin
            @(negedge clk);
            tcnt++;
            lsc_tick = ((tcnt % TICK_DIV) == 0);
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #600000;
        n_err++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        pins  = '0;
        for (int c = 0; c < NCH; c++) set_ch(c, c, 2'b00, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        chk(irq == '0, "R12 irq in reset", int'(irq), 0);
        chk(trig == '0, "R12 trig in reset", int'(trig), 0);
        rst_n = 1'b1;
        watch(0, 10, cnt, first, thi);
        chk(irq == '0 && trig == '0, "R12 after release", int'(irq | trig), 0);

        // Table walk on channel 0.
        foreach (VEC[k]) begin
            logic [19:0] v;
            int sel;
            v   = VEC[k];
            sel = int'(v[15:12]);
            pins = '0;
            set_ch(0, sel, v[11:10], v[9], v[8]);
            pins[sel] = v[7];
            watch(0, 40, cnt, first, thi);
            pins[sel] = v[6];
            watch(0, 60, cnt, first, thi);
            chk(cnt == int'(v[5:4]), $sformatf("R%0d R6 pulse count vec %0d", v[19:16], k),
                cnt, int'(v[5:4]));
            if (v[3:0] != 0)
                chk(first == int'(v[3:0]), $sformatf("R1 R%0d latency vec %0d", v[19:16], k),
                    first, int'(v[3:0]));
        end

        // R7: 2-cycle pulse rejected by the filter.
        pins = '0;
        set_ch(0, 0, 2'b01, 1'b1, 1'b0);
        watch(0, 30, cnt, first, thi);
        pins[0] = 1'b1;
        repeat (2) @(negedge clk);
        pins[0] = 1'b0;
        watch(0, 30, cnt, first, thi);
        chk(cnt == 0, "R7 short pulse filtered", cnt, 0);

        // R9: unfiltered request path passes the glitch, trigger does not.
        set_ch(0, 0, 2'b01, 1'b0, 1'b0);
        watch(0, 30, cnt, first, thi);
        pins[0] = 1'b1;
        repeat (2) @(negedge clk);
        pins[0] = 1'b0;
        watch(0, 30, cnt, first, thi);
        chk(cnt == 1, "R9 request path unfiltered", cnt, 1);
        chk(thi == 1'b0, "R9 trigger stays low on glitch", int'(thi), 0);

        // R9: trigger timing ignores sampling enable.
        set_ch(0, 0, 2'b01, 1'b0, 1'b1);
        watch(0, 30, cnt, first, thi);
        pins[0] = 1'b1;
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            if (i == 4) chk(trig[0] == 1'b0, "R9 trigger before filter", int'(trig[0]), 0);
            if (i == 5) chk(trig[0] == 1'b1, "R9 trigger after filter", int'(trig[0]), 1);
        end
        pins[0] = 1'b0;

        // R8: pulse wholly between two ticks is ignored.
        set_ch(0, 0, 2'b01, 1'b0, 1'b1);
        watch(0, 30, cnt, first, thi);
        @(posedge clk);
        while (!lsc_tick) @(posedge clk);
        @(negedge clk);
        pins[0] = 1'b1;
        repeat (3) @(negedge clk);
        pins[0] = 1'b0;
        watch(0, 40, cnt, first, thi);
        chk(cnt == 0, "R8 inter-tick pulse ignored", cnt, 0);

        // R10: channel 3 follows pin 7, not pin 3.
        set_ch(0, 0, 2'b00, 1'b0, 1'b0);
        set_ch(3, 7, 2'b01, 1'b0, 1'b0);
        watch(3, 30, cnt, first, thi);
        pins[7] = 1'b1;
        watch(3, 20, cnt, first, thi);
        chk(cnt == 1 && first == 3, "R10 selected pin", first, 3);
        pins[3] = 1'b1;
        watch(3, 20, cnt, first, thi);
        chk(cnt == 0, "R10 unselected pin", cnt, 0);
        set_ch(3, 3, 2'b00, 1'b0, 1'b0);
        pins = '0;

        // R11: pin-select switch onto a high pin stays silent.
        set_ch(0, 0, 2'b01, 1'b0, 1'b0);
        pins[1] = 1'b1;
        watch(0, 30, cnt, first, thi);
        set_ch(0, 1, 2'b01, 1'b0, 1'b0);
        watch(0, 40, cnt, first, thi);
        chk(cnt == 0, "R11 select switch", cnt, 0);

        // R11: mode change and pin edge in the same cycle.
        pins = '0;
        set_ch(0, 0, 2'b01, 1'b0, 1'b0);
        watch(0, 30, cnt, first, thi);
        pins[0] = 1'b1;
        set_ch(0, 0, 2'b11, 1'b0, 1'b0);
        watch(0, 40, cnt, first, thi);
        chk(cnt == 0, "R11 coincident edge absorbed", cnt, 0);
        pins[0] = 1'b0;
        watch(0, 20, cnt, first, thi);
        chk(cnt == 1 && first == 3, "R11 reference reloaded", first, 3);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule